// File: doc/BRIEF.md
# Escalating Watchdog Timer

A watchdog that counts bus-clock cycles down from a reload value chosen by a 4-bit range code. Software must write a fixed restart key often enough to keep the count from reaching zero. When the count expires, the block responds in one of two ways. In the direct mode it issues a reset request pulse. In the escalating mode it first raises an interrupt. The reset pulse follows only if a second expiry arrives while that interrupt is still pending.

The reset request is a pulse whose length is selected by a 3-bit code. After every expiry the counter reloads itself and keeps counting. Clearing the interrupt also reloads the counter. Once the watchdog is enabled it stays enabled until the block is reset. The current count can be read at all times.

Top module: `escalating_wdt`

## Requirements
- R1: After rst_ni is low, count_o, irq_o and rst_req_o are 0. The block stays disabled, and count_o holds 0 until it is enabled.
- R2: A cycle with en_we_i=1 and en_i=1 on a disabled block enables it and loads count_o with 2^(BASE+range_i)-1 on that clock edge. While enabled, count_o then falls by one per cycle.
- R3: An enabled count of zero with no restart and no clear in that cycle is an expiry. On that edge the counter reloads 2^(BASE+range_i)-1, so expiries repeat every 2^(BASE+range_i) cycles.
- R4: With mode_i=0 at an expiry, rst_req_o is high from the next cycle.
- R5: pulse_sel_i is sampled at the expiry that fires the reset request. rst_req_o then stays high for exactly 2^(pulse_sel_i+1) cycles, and a further firing expiry during the pulse restarts it.
- R6: With mode_i=1, an expiry while irq_o is low sets irq_o on the next cycle and does not raise rst_req_o.
- R7: With mode_i=1, an expiry while irq_o is high fires the reset request, and irq_o stays high.
- R8: irq_clr_i=1 on an enabled block clears irq_o and reloads the counter on the next edge.
- R9: kick_we_i=1 with kick_data_i=8'h76 on an enabled block reloads the counter. A write with any other data leaves the count falling by one per cycle.
- R10: A valid restart or clear in the same cycle as a zero count takes priority: the counter reloads and no expiry occurs.
- R11: Once enabled, writing en_i=0 has no effect. Only rst_ni disables the block.
- R12: range_i is sampled at each reload, so a change takes effect at the next reload and does not alter the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_we_i | input | 1 | Enable write strobe |
| en_i | input | 1 | Enable write data (only 1 has an effect) |
| range_i | input | 4 | Timeout range code, reload = 2^(BASE+range_i)-1 |
| mode_i | input | 1 | 0: reset on expiry, 1: interrupt first |
| pulse_sel_i | input | 3 | Reset pulse length code, 2^(code+1) cycles |
| kick_we_i | input | 1 | Restart write strobe |
| kick_data_i | input | 8 | Restart write data, key 8'h76 |
| irq_clr_i | input | 1 | Interrupt clear strobe (also reloads) |
| count_o | output | 32 | Current count |
| irq_o | output | 1 | Timeout interrupt |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
Every control input acts on the next clock edge. An enable, a restart or a clear therefore shows up in count_o one cycle after the strobe. After a load, the expiry's effect on irq_o or rst_req_o first appears 2^(BASE+range) cycles later. That is one cycle after count_o reads zero, because the expiry is itself a registered edge. The bench drives and samples on the falling clock edge and counts falling edges from each stimulus. Each expected cycle number and pulse width comes from bench functions of range and pulse code, and the check happens at exactly that edge. The bench is built with BASE=4, so that the longest randomized period is 128 cycles.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  typedef enum logic {
    RESP_RESET     = 1'b0,
    RESP_IRQ_FIRST = 1'b1
  } resp_mode_e;
endpackage

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
  parameter int CNT_W = 32,
  parameter int RNG_W = 4,
  parameter int BASE  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [RNG_W-1:0] range_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tmo_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload = (CNT_W'(1) << (BASE + int'(range_i))) - CNT_W'(1);
  assign tmo_o  = en_i && !load_i && (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= reload;
    else if (en_i) begin
      if (cnt_q == '0)             cnt_q <= reload;
      else                         cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_escalate.sv
`timescale 1ns/1ps
module wdt_escalate
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tmo_i,
  input  resp_mode_e mode_i,
  input  logic       clr_i,
  output logic       irq_o,
  output logic       fire_o
);
  logic irq_q;

  assign fire_o = tmo_i && ((mode_i == RESP_RESET) || irq_q);
  assign irq_o  = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         irq_q <= 1'b0;
    else if (clr_i)                                      irq_q <= 1'b0;
    else if (tmo_i && mode_i == RESP_IRQ_FIRST && !irq_q) irq_q <= 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
`timescale 1ns/1ps
module wdt_pulse #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  localparam int LEN_W = (1 << SEL_W) + 1;

  logic [LEN_W-1:0] left_q;

  assign pulse_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       left_q <= '0;
    else if (fire_i)   left_q <= LEN_W'(2) << sel_i;
    else if (pulse_o)  left_q <= left_q - LEN_W'(1);
  end
endmodule

// File: rtl/escalating_wdt.sv
`timescale 1ns/1ps
module escalating_wdt
  import wdt_pkg::*;
#(
  parameter int          CNT_W = 32,
  parameter int          RNG_W = 4,
  parameter int          SEL_W = 3,
  parameter int          KEY_W = 8,
  parameter int          BASE  = 16,
  parameter logic [7:0]  KEY   = 8'h76
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic             en_i,
  input  logic [RNG_W-1:0] range_i,
  input  logic             mode_i,
  input  logic [SEL_W-1:0] pulse_sel_i,
  input  logic             kick_we_i,
  input  logic [KEY_W-1:0] kick_data_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic       en_q;
  logic       en_rise;
  logic       restart;
  logic       clr;
  logic       load;
  logic       tmo;
  logic       fire;
  resp_mode_e mode;

  assign mode    = resp_mode_e'(mode_i);
  assign en_rise = en_we_i && en_i && !en_q;
  assign restart = en_q && kick_we_i && (kick_data_i == KEY_W'(KEY));
  assign clr     = en_q && irq_clr_i;
  assign load    = en_rise || restart || clr;

  // sticky enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (en_rise) en_q <= 1'b1;
  end

  wdt_counter #(.CNT_W(CNT_W), .RNG_W(RNG_W), .BASE(BASE)) cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .load_i (load),
    .range_i(range_i),
    .cnt_o  (count_o),
    .tmo_o  (tmo)
  );

  wdt_escalate esc_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tmo_i (tmo),
    .mode_i(mode),
    .clr_i (clr),
    .irq_o (irq_o),
    .fire_o(fire)
  );

  wdt_pulse #(.SEL_W(SEL_W)) pls_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .sel_i  (pulse_sel_i),
    .pulse_o(rst_req_o)
  );
endmodule

// File: rtl/wdt_chk.sv
`timescale 1ns/1ps
module wdt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_q,
  input logic             load,
  input logic             tmo,
  input logic [CNT_W-1:0] cnt,
  input logic             mode_i,
  input logic             irq_clr_i,
  input logic             irq_o,
  input logic             rst_req_o
);
  assert_count_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_direct_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo && !mode_i) |=> rst_req_o);

  assert_pulse_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |=> rst_req_o);

  assert_irq_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo && mode_i && !irq_o) |=> (irq_o && !$rose(rst_req_o)));

  assert_escalate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo && mode_i && irq_o) |=> (rst_req_o && irq_o));

  assert_irq_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && irq_clr_i) |=> !irq_o);

  assert_enable_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
endmodule

bind escalating_wdt wdt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_q     (en_q),
  .load     (load),
  .tmo      (tmo),
  .cnt      (count_o),
  .mode_i   (mode_i),
  .irq_clr_i(irq_clr_i),
  .irq_o    (irq_o),
  .rst_req_o(rst_req_o)
);

// File: tb/escalating_wdt_tb_top.sv
`timescale 1ns/1ps
module escalating_wdt_tb_top;
  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_we_i = 1'b0;
  logic        en_i = 1'b0;
  logic [3:0]  range_i = '0;
  logic        mode_i = 1'b0;
  logic [2:0]  pulse_sel_i = '0;
  logic        kick_we_i = 1'b0;
  logic [7:0]  kick_data_i = '0;
  logic        irq_clr_i = 1'b0;
  logic [31:0] count_o;
  logic        irq_o;
  logic        rst_req_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  escalating_wdt #(.BASE(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_we_i(en_we_i), .en_i(en_i),
    .range_i(range_i), .mode_i(mode_i), .pulse_sel_i(pulse_sel_i),
    .kick_we_i(kick_we_i), .kick_data_i(kick_data_i), .irq_clr_i(irq_clr_i),
    .count_o(count_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic int exp_load(input int r);
    return (1 << (BASE + r)) - 1;
  endfunction

  function automatic int exp_pulse(input int s);
    return 2 << s;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; en_we_i = 0; en_i = 0; kick_we_i = 0; irq_clr_i = 0;
    tick(2);
    rst_ni = 1'b1;
    tick(1);
  endtask

  task automatic enable(input int r, input bit m, input int s);
    range_i = 4'(r); mode_i = m; pulse_sel_i = 3'(s);
    en_we_i = 1; en_i = 1;
    tick(1);
    en_we_i = 0; en_i = 0;
  endtask

  task automatic wait_for(input bit on_irq, input int max, output int cyc);
    cyc = 0;
    while (((on_irq ? irq_o : rst_req_o) == 1'b0) && cyc < max) begin
      tick(1); cyc++;
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (rst_req_o && w < 1000) begin
      w++; tick(1);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cyc, w, r, s;
    bit m;
    void'($urandom(32'd20240611));

    // R1: reset state, no counting while disabled
    do_reset();
    check("R1 count", count_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 rst_req", rst_req_o, 0);
    tick(5);
    check("R1 idle count", count_o, 0);

    // R2: enable loads and counts down
    enable(0, 1'b0, 0);
    check("R2 load", count_o, exp_load(0));
    tick(3);
    check("R2 decrement", count_o, exp_load(0) - 3);
    // R11: disable attempt ignored
    en_we_i = 1; en_i = 0; tick(1); en_we_i = 0;
    check("R11 still counting", count_o, exp_load(0) - 4);
    // R9: wrong key ignored, right key reloads
    kick_we_i = 1; kick_data_i = 8'h75; tick(1); kick_we_i = 0;
    check("R9 bad key", count_o, exp_load(0) - 5);
    kick_we_i = 1; kick_data_i = 8'h76; tick(1); kick_we_i = 0;
    check("R9 good key", count_o, exp_load(0));
    // R12: range change waits for the next reload
    range_i = 4'd1;
    tick(1);
    check("R12 no effect mid-count", count_o, exp_load(0) - 1);
    tick(exp_load(0) - 1);
    check("R10 at zero", count_o, 0);
    // R10: restart at zero beats expiry
    kick_we_i = 1; kick_data_i = 8'h76; tick(1); kick_we_i = 0;
    check("R10 reload", count_o, exp_load(1));
    check("R10 no reset", rst_req_o, 0);
    // R3/R4: expiry period and direct reset
    wait_for(1'b0, 1000, cyc);
    check("R3 R4 period", cyc, exp_load(1) + 1);
    check("R3 reload after expiry", count_o, exp_load(1));
    pulse_width(w);
    check("R5 pulse width", w, exp_pulse(0));

    // R6/R8/R7: escalating mode
    do_reset();
    enable(0, 1'b1, 1);
    wait_for(1'b1, 1000, cyc);
    check("R6 irq period", cyc, exp_load(0) + 1);
    check("R6 no reset", rst_req_o, 0);
    tick(2);
    irq_clr_i = 1; tick(1); irq_clr_i = 0;
    check("R8 irq cleared", irq_o, 0);
    check("R8 reload", count_o, exp_load(0));
    wait_for(1'b1, 1000, cyc);
    check("R6 irq again", cyc, exp_load(0) + 1);
    wait_for(1'b0, 1000, cyc);
    check("R7 escalate period", cyc, exp_load(0) + 1);
    check("R7 irq held", irq_o, 1);
    pulse_width(w);
    check("R7 R5 pulse width", w, exp_pulse(1));

    // randomized ranges, modes and pulse lengths
    for (int i = 0; i < 10; i++) begin
      r = $urandom_range(0, 3);
      s = $urandom_range(0, 2 + r);
      m = 1'($urandom_range(0, 1));
      do_reset();
      enable(r, m, s);
      check("R2 rand load", count_o, exp_load(r));
      if (m) begin
        wait_for(1'b1, 1000, cyc);
        check("R6 rand irq period", cyc, exp_load(r) + 1);
        check("R6 rand no reset", rst_req_o, 0);
      end
      wait_for(1'b0, 1000, cyc);
      check("R3 rand period", cyc, exp_load(r) + 1);
      pulse_width(w);
      check("R5 rand pulse width", w, exp_pulse(s));
    end

    finish_run();
  end
endmodule